// File: doc/BRIEF.md
# Positional Bit-Count Accumulator

This block takes a stream of bytes and keeps one running counter per bit position. After a job, counter j holds how many of the job's bytes had bit j set. This is a vertical count across the stream, not the horizontal popcount of any single byte. A job begins with a one-cycle start pulse that carries the number of bytes to process. The bytes then arrive on a valid/ready handshake.

Bytes are gathered in blocks of up to eight. Each block goes into a 64-bit staging word that was cleared beforehand, so the lanes the block does not fill stay zero. The staging word is treated as an 8x8 bit matrix and transposed, which turns bit position j of every byte into byte j of the result. Eight popcount lanes then count each transposed byte, and each lane adds its result to its own counter in one cycle. All eight lanes run on every block. A short final block is handled by the zero padding alone, with no special-case logic.

Top module: `posbit_tally`

## Requirements
- R1: When done is high, counter j (bits j*CNT_W to j*CNT_W+CNT_W-1 of `tally_o`) equals the number of job bytes with bit j set, for every j from 0 to 7.
- R2: A start accepted while idle clears all counters on the next cycle. A start with an element count of zero raises done on the next cycle, with all counters at zero.
- R3: A job accepts exactly the requested number of bytes. After the last byte, `in_ready_o` stays low until the next start, even while `in_valid_i` is high.
- R4: Bytes are taken in blocks of min(remaining, 8). After each block's last byte, `in_ready_o` drops for exactly one accumulate cycle. A job of N bytes therefore shows ceil(N/8) such cycles before done.
- R5: A short block adds nothing from its unfilled lanes. Bytes left over from an earlier block of the same job never count twice.
- R6: `done_o` is a single-cycle pulse. It rises in the cycle after the last block is accumulated, with `in_ready_o` low. The counters then hold their values.
- R7: While `in_valid_i` is low during loading, the counters stay unchanged and no byte is lost or repeated.
- R8: A start pulse during a running job is ignored. The job keeps its original count, and its counters are not cleared.
- R9: Counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle job start; sampled only while idle |
| elem_count_i | input | LEN_W | Number of bytes in the job, sampled with start |
| in_valid_i | input | 1 | Byte stream valid |
| in_data_i | input | 8 | Byte stream data |
| in_ready_o | output | 1 | Byte stream ready; a byte is taken when valid and ready are both high |
| tally_o | output | 8*CNT_W | Eight counters; counter j is in bits j*CNT_W to j*CNT_W+CNT_W-1 |
| done_o | output | 1 | One-cycle pulse at the end of a job |

## Verification
The counters clear one clock after the start edge. A zero-count job raises done at that same edge. A byte is accepted on the edge where valid and ready are both high. The accumulate cycle follows the edge that takes a block's last byte, and done rises at the edge that ends the final accumulate cycle. The bench drives inputs and samples outputs on the falling edge. It decides whether a byte is accepted from the ready value it sees while driving, and it compares the counters in the first falling edge where done is high. For the ready and done checks, it also looks at the falling edges just after that one.

// File: rtl/posbit_pkg.sv
package posbit_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 8;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int LIDX_W = $clog2(LANES);
  localparam int PCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_FOLD = 2'd2
  } tally_state_e;

  function automatic logic [PCNT_W-1:0] ones_in_byte(input logic [BYTE_W-1:0] b);
    logic [PCNT_W-1:0] n;
    n = '0;
    for (int k = 0; k < BYTE_W; k++) n = n + PCNT_W'(b[k]);
    return n;
  endfunction
endpackage

// File: rtl/posbit_rst_sync.sv
module posbit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/posbit_ctrl.sv
module posbit_ctrl
  import posbit_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  elem_count_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              load_o,
  output logic [LIDX_W-1:0] lane_o,
  output logic              clr_stage_o,
  output logic              clr_cnt_o,
  output logic              fold_o,
  output logic              busy_o,
  output logic              done_o
);
  tally_state_e      st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [LIDX_W-1:0] lane_q, lane_d;
  logic              done_q, done_d;
  logic              take_job;
  logic              last_lane;

  assign take_job  = (st_q == ST_IDLE) && start_i;
  assign last_lane = (lane_q == LIDX_W'(LANES - 1));

  // next-state logic
  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    lane_d = lane_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          rem_d  = elem_count_i;
          lane_d = '0;
          if (elem_count_i == '0) done_d = 1'b1;
          else                    st_d   = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (in_valid_i) begin
          rem_d  = rem_q - LEN_W'(1);
          lane_d = lane_q + LIDX_W'(1);
          if (last_lane || (rem_q == LEN_W'(1))) st_d = ST_FOLD;
        end
      end
      ST_FOLD: begin
        lane_d = '0;
        if (rem_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_LOAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      lane_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (take_job || load_o || fold_o) begin
        rem_q  <= rem_d;
        lane_q <= lane_d;
      end
    end
  end

  assign in_ready_o  = (st_q == ST_LOAD);
  assign load_o      = in_ready_o && in_valid_i;
  assign lane_o      = lane_q;
  assign fold_o      = (st_q == ST_FOLD);
  assign clr_cnt_o   = take_job;
  assign clr_stage_o = take_job || fold_o;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/posbit_stage.sv
module posbit_stage
  import posbit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [LIDX_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (clr_i)       word_d = '0;
    else if (load_i) word_d[lane_i*BYTE_W +: BYTE_W] = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               word_q <= '0;
    else if (clr_i || load_i) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/posbit_transpose.sv
module posbit_transpose
  import posbit_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] flip_o
);
  // byte r of the result gathers bit r of every source byte; source byte c lands in bit c
  for (genvar r = 0; r < LANES; r++) begin : g_row
    for (genvar c = 0; c < BYTE_W; c++) begin : g_col
      assign flip_o[r*BYTE_W + c] = word_i[c*BYTE_W + r];
    end
  end
endmodule

// File: rtl/posbit_lane_acc.sv
module posbit_lane_acc
  import posbit_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              fold_i,
  input  logic [BYTE_W-1:0] col_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PCNT_W-1:0] ones;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign ones = ones_in_byte(col_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (fold_i) cnt_d = cnt_q + CNT_W'(ones);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || fold_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/posbit_tally.sv
module posbit_tally
  import posbit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       elem_count_i,
  input  logic                   in_valid_i,
  input  logic [BYTE_W-1:0]      in_data_i,
  output logic                   in_ready_o,
  output logic [LANES*CNT_W-1:0] tally_o,
  output logic                   done_o
);
  logic              rst_n_s;
  logic              load, clr_stage, clr_cnt, fold, busy;
  logic [LIDX_W-1:0] lane;
  logic [WORD_W-1:0] stage_word, flip_word;

  posbit_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  posbit_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (start_i),
    .elem_count_i (elem_count_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .load_o       (load),
    .lane_o       (lane),
    .clr_stage_o  (clr_stage),
    .clr_cnt_o    (clr_cnt),
    .fold_o       (fold),
    .busy_o       (busy),
    .done_o       (done_o)
  );

  posbit_stage u_stage (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (clr_stage),
    .load_i (load),
    .lane_i (lane),
    .data_i (in_data_i),
    .word_o (stage_word)
  );

  posbit_transpose u_flip (
    .word_i (stage_word),
    .flip_o (flip_word)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    posbit_lane_acc #(.CNT_W(CNT_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .clr_i  (clr_cnt),
      .fold_i (fold),
      .col_i  (flip_word[j*BYTE_W +: BYTE_W]),
      .cnt_o  (tally_o[j*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/posbit_tally_chk.sv
module posbit_tally_chk
  import posbit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input logic                   clk,
  input logic                   rst_n_s,
  input logic                   busy,
  input logic                   start_i,
  input logic [LEN_W-1:0]       elem_count_i,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic [LANES*CNT_W-1:0] tally_o,
  input logic                   done_o
);
  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);

  // R6: no byte is taken while done is shown
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !in_ready_o);

  // R2: an accepted start leaves all counters at zero
  a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && !busy) |=> (tally_o == '0));

  // R2: an empty job finishes at once
  a_r2_zero_job: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && !busy && elem_count_i == '0) |=> done_o);

  // R7: a stalled load leaves the counters alone
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_ready_o && !in_valid_i) |=> $stable(tally_o));

  // R8: a start during a job does not end or restart it
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && start_i && in_ready_o) |=> (busy && !done_o));
endmodule

bind posbit_tally posbit_tally_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .busy         (busy),
  .start_i      (start_i),
  .elem_count_i (elem_count_i),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .tally_o      (tally_o),
  .done_o       (done_o)
);

// File: tb/test_posbit_tally.sv
module test_posbit_tally;
  localparam int CW = 8;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [LW-1:0] elem_count_i;
  logic          in_valid_i;
  logic [7:0]    in_data_i;
  logic          in_ready_o;
  logic [8*CW-1:0] tally_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  buf_q [0:511];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  posbit_tally #(.CNT_W(CW), .LEN_W(LW)) i_posbit_tally (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .elem_count_i(elem_count_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .tally_o(tally_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit lfsr_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // gaps: insert valid-low cycles; mid_start: pulse start during the job
  task automatic run_job(input int n, input bit gaps, input bit mid_start, input string req);
    int exp_cnt [8];
    int idx = 0, lows = 0, cyc = 0;
    bit v;
    for (int j = 0; j < 8; j++) begin
      exp_cnt[j] = 0;
      for (int i = 0; i < n; i++) exp_cnt[j] += int'(buf_q[i][j]);
      exp_cnt[j] = exp_cnt[j] % (1 << CW);
    end
    @(negedge clk);
    start_i = 1'b1; elem_count_i = LW'(n);
    @(negedge clk);
    start_i = 1'b0; elem_count_i = LW'(7);
    while (!done_o && cyc < 5000) begin
      start_i = mid_start && (cyc == 3);
      if (start_i) elem_count_i = LW'(5);
      v = gaps ? lfsr_bit() : 1'b1;
      in_valid_i = v;
      in_data_i  = (idx < 512) ? buf_q[idx] : 8'hA5;
      if (in_ready_o && v) idx++;
      if (!in_ready_o) lows++;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    in_valid_i = 1'b0;
    chk(done_o, "R6", $sformatf("done seen, n=%0d", n), done_o, 1);
    for (int j = 0; j < 8; j++)
      chk(tally_o[j*CW +: CW] == CW'(exp_cnt[j]), req,
          $sformatf("counter %0d, n=%0d", j, n), tally_o[j*CW +: CW], exp_cnt[j]);
    chk(idx == n, "R3", $sformatf("bytes taken, n=%0d", n), idx, n);
    chk(lows == (n + 7) / 8, "R4", $sformatf("accumulate cycles, n=%0d", n), lows, (n + 7) / 8);
    // after done: one pulse only, no intake, counters hold
    in_valid_i = 1'b1; in_data_i = 8'hFF;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!done_o, "R6", "done single cycle", done_o, 0);
      chk(!in_ready_o, "R3", "ready low after job", in_ready_o, 0);
      for (int j = 0; j < 8; j++)
        chk(tally_o[j*CW +: CW] == CW'(exp_cnt[j]), "R6",
            $sformatf("counter %0d holds", j), tally_o[j*CW +: CW], exp_cnt[j]);
    end
    in_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; elem_count_i = '0;
    in_valid_i = 1'b0; in_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(tally_o == '0, "R2", "counters after reset", tally_o, 0);
    chk(!done_o, "R6", "done after reset", done_o, 0);
    chk(!in_ready_o, "R3", "ready after reset", in_ready_o, 0);

    // R2: empty job
    run_job(0, 1'b0, 1'b0, "R2");

    // R1/R4: sweep of lengths 1..17, also crossing block borders
    for (int n = 1; n <= 17; n++) begin
      for (int i = 0; i < n; i++) buf_q[i] = 8'(i * 37 + n * 11 + 3);
      run_job(n, 1'b0, 1'b0, "R1");
    end

    // R7: every byte value once, with stalls
    for (int i = 0; i < 256; i++) buf_q[i] = 8'(i);
    run_job(256, 1'b1, 1'b0, "R7");

    // R5: full block of ones, then a short block of one zero byte
    for (int i = 0; i < 8; i++) buf_q[i] = 8'hFF;
    buf_q[8] = 8'h00;
    run_job(9, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 8; i++) buf_q[i] = 8'h5A;
    buf_q[8] = 8'h01; buf_q[9] = 8'h80;
    run_job(10, 1'b1, 1'b0, "R5");

    // R8: start pulse in mid job is ignored
    for (int i = 0; i < 20; i++) buf_q[i] = 8'(8'hC3 ^ i);
    run_job(20, 1'b0, 1'b1, "R8");

    // R9: counters wrap at 2^CW (300 bytes of all ones -> 44)
    for (int i = 0; i < 300; i++) buf_q[i] = 8'hFF;
    run_job(300, 1'b1, 1'b0, "R9");

    finish_run();
  end
endmodule